// File: doc/BRIEF.md
# Pulser Gate State Decoder

This block sits between the pattern and delay logic of a multi-channel transmit pulser and the gate drivers of the output stage. On every clock it takes one pattern bit pair per channel, a global enable, a polarity-invert control, a continuous-wave mode control and a divided-clock strobe. From these it produces three registered gate enables per channel: one for the high-side switch, one for the low-side switch and one for the return-to-zero damping switch. Exactly one of four output states applies at any time: drive high, drive low, return to zero, or high impedance.

In pattern mode the pair of pattern bits selects the state. Setting both bits requests high impedance, so the two drive switches can never conduct together. The invert control swaps the drive polarity for second-harmonic work. Between transmissions each channel is held at return to zero. In continuous-wave mode the pattern bits are ignored. Every channel that is not switched off alternates between high and low drive, and the block halves the divided-clock strobe to set that rate. A channel whose delay code marks it off keeps all three switches open.

Top module: `pulser_gate_decoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, all gate enables of all channels are 0 after that edge.
- R2: With `en` low, all three gate enables of every channel are 0, whatever the other inputs are.
- R3: With `en` high, `cw_mode` low and `active` low, each channel has only its damping enable (`rtz_gate`) set.
- R4: With `en` high, `cw_mode` low and `active` high, a channel whose pair is (p=0, n=0) has only `rtz_gate` set.
- R5: With `inv` low in pattern mode, the pair (p=1, n=0) sets only `hi_gate` and the pair (p=0, n=1) sets only `lo_gate`.
- R6: In pattern mode the pair (p=1, n=1) clears all three gate enables (high impedance), and `inv` does not change this.
- R7: With `inv` high in pattern mode, (p=1, n=0) sets only `lo_gate` and (p=0, n=1) sets only `hi_gate`. The (0,0) and (1,1) pairs keep their R4 and R6 results.
- R8: With `en` and `cw_mode` high, a channel that is not off ignores `p_bits`, `n_bits`, `active` and `inv`. It drives `hi_gate` when the internal phase is 1 and `lo_gate` when the phase is 0. The phase inverts on each clock that has `div_tick` high, so the output toggles at half the strobe rate.
- R9: With `en` and `cw_mode` high, a channel whose `chan_off` bit is 1 has all three gate enables at 0.
- R10: The phase is 0 whenever `cw_mode` is low. The first continuous-wave output after entry therefore drives `lo_gate`.
- R11: On no channel is more than one of `hi_gate`, `lo_gate` and `rtz_gate` set at once. In particular, high side and low side are never on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Global enable; low opens every switch |
| inv | input | 1 | Swaps high/low drive in pattern mode |
| cw_mode | input | 1 | Selects continuous-wave mode |
| div_tick | input | 1 | One-cycle strobe from the clock divider |
| active | input | 1 | A pattern transmission is in progress |
| p_bits | input | NCH | Per-channel high-side pattern bit |
| n_bits | input | NCH | Per-channel low-side pattern bit |
| chan_off | input | NCH | Per-channel off flag (delay code all ones) |
| hi_gate | output | NCH | High-side switch enable per channel |
| lo_gate | output | NCH | Low-side switch enable per channel |
| rtz_gate | output | NCH | Return-to-zero damping switch enable per channel |

## Verification
Every gate enable appears one clock after the inputs that decide it, because the decoded state passes through a single register stage. The bench changes the inputs on the falling edge and compares the outputs at the next falling edge against a value it computed when it drove those inputs. The continuous-wave phase updates on the same edge that registers the output, so an output shows the phase from before its edge. The bench model follows this by computing the expected value from its current phase and only then advancing the phase for the next strobe.

// File: rtl/pgd_pkg.sv
// Shared types for the pulser gate state decoder.
// Assumes: four output states, encoded in two bits.
package pgd_pkg;
    typedef enum logic [1:0] {
        GS_HIZ  = 2'd0,
        GS_HIGH = 2'd1,
        GS_LOW  = 2'd2,
        GS_RTZ  = 2'd3
    } gate_state_e;
endpackage

// File: rtl/pgd_cw_phase.sv
// Continuous-wave phase: halves the divided-clock strobe.
// Assumes: div_tick is a one-cycle pulse; the phase is held at 0 outside CW mode.
module pgd_cw_phase (
    input  logic clk,
    input  logic rst_n,
    input  logic cw_mode,
    input  logic div_tick,
    output logic phase
);
    // Toggle on each strobe in CW mode, clear otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !cw_mode)
            phase <= 1'b0;
        else if (div_tick)
            phase <= ~phase;
    end
endmodule

// File: rtl/pgd_chan_decode.sv
// Per-channel state selection from mode controls and the pattern bit pair.
// Assumes: purely combinational; the caller registers the result.
module pgd_chan_decode
    import pgd_pkg::*;
(
    input  logic        en,
    input  logic        inv,
    input  logic        cw_mode,
    input  logic        active,
    input  logic        p_bit,
    input  logic        n_bit,
    input  logic        is_off,
    input  logic        cw_phase,
    output gate_state_e state
);
    // Priority: disable, CW override, idle damping, pattern decode.
    always_comb begin
        state = GS_HIZ;
        if (!en) begin
            state = GS_HIZ;
        end else if (cw_mode) begin
            if (is_off)
                state = GS_HIZ;
            else
                state = cw_phase ? GS_HIGH : GS_LOW;
        end else if (!active) begin
            state = GS_RTZ;
        end else begin
            unique case ({p_bit, n_bit})
                2'b00: state = GS_RTZ;
                2'b10: state = inv ? GS_LOW : GS_HIGH;
                2'b01: state = inv ? GS_HIGH : GS_LOW;
                default: state = GS_HIZ;
            endcase
        end
    end
endmodule

// File: rtl/pgd_gate_reg.sv
// Registers a channel state into three gate enables.
// Assumes: at most one enable follows from any state; reset opens all switches.
module pgd_gate_reg
    import pgd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  gate_state_e state,
    output logic        hi_en,
    output logic        lo_en,
    output logic        rtz_en
);
    // Expand the state into registered switch enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_en  <= 1'b0;
            lo_en  <= 1'b0;
            rtz_en <= 1'b0;
        end else begin
            hi_en  <= (state == GS_HIGH);
            lo_en  <= (state == GS_LOW);
            rtz_en <= (state == GS_RTZ);
        end
    end
endmodule

// File: rtl/pulser_gate_decoder.sv
// Top: NCH channels of gate state decoding sharing one CW phase.
// Assumes: all inputs are synchronous to clk; outputs lag inputs by one clock.
module pulser_gate_decoder
    import pgd_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic           inv,
    input  logic           cw_mode,
    input  logic           div_tick,
    input  logic           active,
    input  logic [NCH-1:0] p_bits,
    input  logic [NCH-1:0] n_bits,
    input  logic [NCH-1:0] chan_off,
    output logic [NCH-1:0] hi_gate,
    output logic [NCH-1:0] lo_gate,
    output logic [NCH-1:0] rtz_gate
);
    logic cw_phase;

    pgd_cw_phase u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .cw_mode  (cw_mode),
        .div_tick (div_tick),
        .phase    (cw_phase)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        gate_state_e st;

        pgd_chan_decode u_dec (
            .en       (en),
            .inv      (inv),
            .cw_mode  (cw_mode),
            .active   (active),
            .p_bit    (p_bits[ch]),
            .n_bit    (n_bits[ch]),
            .is_off   (chan_off[ch]),
            .cw_phase (cw_phase),
            .state    (st)
        );

        pgd_gate_reg u_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .state  (st),
            .hi_en  (hi_gate[ch]),
            .lo_en  (lo_gate[ch]),
            .rtz_en (rtz_gate[ch])
        );
    end
endmodule

// File: rtl/pgd_checker.sv
// Temporal checks on the decoder ports, bound to every instance of the top.
// Assumes: ports mirror the top's names.
module pgd_checker #(
    parameter int NCH = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           en,
    input logic           inv,
    input logic           cw_mode,
    input logic           div_tick,
    input logic           active,
    input logic [NCH-1:0] p_bits,
    input logic [NCH-1:0] n_bits,
    input logic [NCH-1:0] chan_off,
    input logic [NCH-1:0] hi_gate,
    input logic [NCH-1:0] lo_gate,
    input logic [NCH-1:0] rtz_gate
);
    AST_DISABLED_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (hi_gate == '0 && lo_gate == '0 && rtz_gate == '0)); // R2

    AST_IDLE_DAMPED: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !cw_mode && !active) |=> (rtz_gate == '1 && hi_gate == '0 && lo_gate == '0)); // R3

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chk
        AST_ONE_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0({hi_gate[ch], lo_gate[ch], rtz_gate[ch]})); // R11

        AST_BOTH_BITS_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
            (en && !cw_mode && active && p_bits[ch] && n_bits[ch])
            |=> !(hi_gate[ch] || lo_gate[ch] || rtz_gate[ch])); // R6

        AST_CW_OFF_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
            (en && cw_mode && chan_off[ch])
            |=> !(hi_gate[ch] || lo_gate[ch] || rtz_gate[ch])); // R9

        AST_CW_ENTRY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(cw_mode) && en && !chan_off[ch]) |=> lo_gate[ch]); // R10
    end
endmodule

bind pulser_gate_decoder pgd_checker #(.NCH(NCH)) u_chk (.*);

// File: tb/sim_pulser_gate_decoder.sv
// Bench: fixed-seed random stimulus plus directed corners, compared with a model.
module sim_pulser_gate_decoder;
    localparam int NCH    = 8;
    localparam int CLK_NS = 10;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           en = 1'b0, inv = 1'b0, cw_mode = 1'b0, div_tick = 1'b0, active = 1'b0;
    logic [NCH-1:0] p_bits = '0, n_bits = '0, chan_off = '0;
    logic [NCH-1:0] hi_gate, lo_gate, rtz_gate;

    int total = 0;
    int bad   = 0;
    logic           m_phase = 1'b0;
    logic [2:0]     exp_g [NCH];
    string          exp_tag [NCH];
    logic           have_exp = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    pulser_gate_decoder #(.NCH(NCH)) u0 (.*);

    // Expected {hi,lo,rtz} of one channel from the requirements.
    function automatic logic [2:0] model_gate(logic r, logic e, logic iv, logic cw,
                                              logic act, logic p, logic n,
                                              logic off, logic ph);
        if (!r) return 3'b000;                           // R1
        if (!e) return 3'b000;                           // R2
        if (cw) begin
            if (off) return 3'b000;                      // R9
            return ph ? 3'b100 : 3'b010;                 // R8 R10
        end
        if (!act) return 3'b001;                         // R3
        case ({p, n})
            2'b00: return 3'b001;                        // R4
            2'b11: return 3'b000;                        // R6
            2'b10: return iv ? 3'b010 : 3'b100;          // R5 R7
            default: return iv ? 3'b100 : 3'b010;
        endcase
    endfunction

    function automatic string model_tag(logic r, logic e, logic iv, logic cw,
                                        logic act, logic p, logic n, logic off);
        if (!r) return "R1";
        if (!e) return "R2";
        if (cw) return off ? "R9" : "R8 R10";
        if (!act) return "R3";
        if (p == n) return p ? "R6" : "R4";
        return iv ? "R7" : "R5";
    endfunction

    // Compare outputs against the value predicted one clock earlier.
    task automatic check_outputs();
        if (!have_exp) return;
        for (int ch = 0; ch < NCH; ch++) begin
            logic [2:0] got;
            got = {hi_gate[ch], lo_gate[ch], rtz_gate[ch]};
            total++;
            if (got !== exp_g[ch]) begin
                bad++;
                $display("FAIL %s ch%0d gates(hi,lo,rtz) got=%b exp=%b",
                         exp_tag[ch], ch, got, exp_g[ch]);
            end
            total++;
            if (got[2] && got[1]) begin // R11
                bad++;
                $display("FAIL R11 ch%0d gates got=%b exp=hi,lo not both", ch, got);
            end
        end
    endtask

    // One cycle: check previous prediction, drive new inputs, predict, advance phase.
    task automatic step(logic r, logic e, logic iv, logic cw, logic tk, logic act,
                        logic [NCH-1:0] p, logic [NCH-1:0] n, logic [NCH-1:0] off);
        @(negedge clk);
        check_outputs();
        rst_n = r; en = e; inv = iv; cw_mode = cw; div_tick = tk; active = act;
        p_bits = p; n_bits = n; chan_off = off;
        for (int ch = 0; ch < NCH; ch++) begin
            exp_g[ch]   = model_gate(r, e, iv, cw, act, p[ch], n[ch], off[ch], m_phase);
            exp_tag[ch] = model_tag(r, e, iv, cw, act, p[ch], n[ch], off[ch]);
        end
        have_exp = 1'b1;
        if (!r || !cw) m_phase = 1'b0;
        else if (tk)   m_phase = ~m_phase;
    endtask

    initial begin : watchdog
        #(CLK_NS * 150000);
        bad++;
        $display("FAIL watchdog expired got=hung exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        logic cw_r;
        void'($urandom(32'd4242));
        // R1: reset with busy inputs
        step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'hF0, 8'h0F, 8'h00);
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'hAA, 8'h55, 8'h00);
        // R3: idle between transmissions
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 8'h00, 8'h00);
        // R4 R5 R6: every pair, not inverted
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'b1100_1010, 8'b1010_0110, 8'h00);
        // R7: same pairs, inverted
        step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'b1100_1010, 8'b1010_0110, 8'h00);
        // R2: disabled with drive pattern
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFF, 8'h00, 8'h00);
        // R10 R8 R9: CW entry with strobe at once, some channels off, inv ignored
        step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'hFF, 8'h00, 8'h81);
        step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'hFF, 8'h81);
        step(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 8'h81);
        step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h3C, 8'hC3, 8'h81);
        // R10: leave and re-enter CW with phase high before leaving
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00, 8'h00);
        step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00);
        // Random mix of all requirements
        cw_r = 1'b0;
        for (int i = 0; i < 1500; i++) begin
            logic r, e, iv, tk, act;
            if (($urandom % 16) == 0) cw_r = ~cw_r;
            r   = (($urandom % 64) != 0);
            e   = (($urandom % 8) != 0);
            iv  = $urandom % 2;
            tk  = (($urandom % 3) == 0);
            act = (($urandom % 4) != 0);
            step(r, e, iv, cw_r, tk, act, NCH'($urandom), NCH'($urandom), NCH'($urandom));
        end
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00);
        @(negedge clk);
        check_outputs();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule